// File: doc/BRIEF.md
# Bit-Addressable Memory Access Unit

This unit carries out single-bit instructions for an 8-bit microcontroller datapath. Each accepted operation names an 8-bit bit address and an opcode. The unit turns the bit address into a byte address and a bit index. It reads that byte from the data memory / special-register port, works on the selected bit, and writes the byte back when the operation changes the bit. It also keeps the one-bit carry accumulator and produces a condition output that a branch unit can use.

Bit addresses below 80h select bits in a 16-byte RAM window that starts at 20h. Bit addresses from 80h upward select special-register bytes whose address is a multiple of 8.

The unit is a two-stage pipeline and accepts one operation per cycle:
- Stage A issues the read.
- Stage B computes the result, writes the byte back, and reports the condition.

Read and write use separate address lanes, so the read for operation N+1 overlaps the write for operation N. A back-to-back hazard on the same byte is resolved by forwarding the merged write data.

The byte at the status address (D0h) holds the carry flag in bit 7. The unit keeps that bit consistent with its internal carry register.

Top module: `bitop_unit`

## Requirements
- R1: A bit address A below 80h selects byte 20h + A[6:3] and bit A[2:0]. The whole low region therefore covers bytes 20h..2Fh.
- R2: A bit address A of 80h or above selects byte {A[7:3],3'b000} and bit A[2:0].
- R3: A bit write is a read-modify-write of the whole byte. The written byte differs from the byte that was read in at most the selected bit.
- R4: Opcode 1 sets C = C & b. Opcode 2 sets C = C & ~b. Opcode 3 sets C = C | b. Opcode 4 sets C = C | ~b. In each case b is the addressed bit, and memory is not written.
- R5: Opcode 5 copies the addressed bit into C without writing memory. Opcode 6 writes C into the addressed bit and leaves C unchanged.
- R6: Opcode 7 clears C, opcode 8 sets C and opcode 9 complements C. None of these three opcodes reads or writes memory.
- R7: Opcode 10 clears the addressed bit, opcode 11 sets it and opcode 12 complements it. Each of these opcodes always writes the byte back.
- R8: Opcode 13 (test-and-clear) drives cond_o to the old bit value. It writes the bit back as 0 only when the bit was 1, and performs no write when the bit was 0.
- R9: Opcode 14 drives cond_o to the addressed bit and opcode 15 drives cond_o to its inverse. Neither opcode writes memory. All other opcodes drive cond_o to 0.
- R10: A read of status byte D0h sees the current carry in bit 7. A bit write to bit 7 of D0h (bit address D7h) also updates C.
- R11: Two operations issued in consecutive cycles give the same memory and carry results as the same two operations issued far apart. This holds when they touch the same byte and when the first one changes the carry.
- R12: Take the cycle after op_valid_i is accepted. In that cycle the unit issues mem_rd_o and mem_raddr_o. In the next cycle it drives done_o, cond_o and any write. The new carry appears on carry_o one cycle after that.
- R13: During reset carry_o is 0, and mem_rd_o, mem_wr_o, done_o and cond_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Accept an operation this cycle |
| op_i | input | 4 | Opcode |
| bit_addr_i | input | 8 | Bit address |
| mem_rd_o | output | 1 | Read strobe |
| mem_raddr_o | output | 8 | Read byte address |
| mem_rdata_i | input | 8 | Read data, combinational from mem_raddr_o |
| mem_wr_o | output | 1 | Write strobe, taken at the next rising edge |
| mem_waddr_o | output | 8 | Write byte address |
| mem_wdata_o | output | 8 | Merged write byte |
| carry_o | output | 1 | Carry accumulator |
| cond_o | output | 1 | Branch condition, valid with done_o |
| done_o | output | 1 | Operation completes this cycle |

## Verification
A wrong byte or bit decode shows on mem_raddr_o one cycle after issue. A wrong merge or a lost forward shows in the written byte two cycles after issue. A wrong carry becomes visible on carry_o three cycles after issue, or in the condition or write of the next dependent operation.

The bench sweeps all 256 bit addresses against every opcode. After each operation it compares the read address, the condition, the carry, the number of write strobes and the whole target byte against an arithmetic model. Directed back-to-back pairs then exercise the forwarding paths and the status-bit aliasing.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_ANL   = 4'd1,
    OP_ANL_N = 4'd2,
    OP_ORL   = 4'd3,
    OP_ORL_N = 4'd4,
    OP_MOV_C = 4'd5,
    OP_MOV_B = 4'd6,
    OP_CLR_C = 4'd7,
    OP_SET_C = 4'd8,
    OP_CPL_C = 4'd9,
    OP_CLR_B = 4'd10,
    OP_SET_B = 4'd11,
    OP_CPL_B = 4'd12,
    OP_JBC   = 4'd13,
    OP_JB    = 4'd14,
    OP_JNB   = 4'd15
  } bit_op_e;

  function automatic logic op_uses_mem(bit_op_e op);
    case (op)
      OP_NOP, OP_CLR_C, OP_SET_C, OP_CPL_C: op_uses_mem = 1'b0;
      default:                              op_uses_mem = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/bitop_addr_dec.sv
module bitop_addr_dec #(
  parameter int unsigned               ADDR_W   = 8,
  parameter int unsigned               DATA_W   = 8,
  parameter logic [ADDR_W-1:0]         RAM_BASE = 8'h20
) (
  input  logic [ADDR_W-1:0]            bit_addr_i,
  output logic [ADDR_W-1:0]            byte_addr_o,
  output logic [$clog2(DATA_W)-1:0]    bit_idx_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] ram_byte;
  logic [ADDR_W-1:0] sfr_byte;

  assign ram_byte    = RAM_BASE + ADDR_W'(bit_addr_i[ADDR_W-2:IDX_W]);
  assign sfr_byte    = {bit_addr_i[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
  assign byte_addr_o = bit_addr_i[ADDR_W-1] ? sfr_byte : ram_byte;
  assign bit_idx_o   = bit_addr_i[IDX_W-1:0];
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
(
  input  bit_op_e op_i,
  input  logic    bit_i,
  input  logic    carry_i,
  output logic    bit_o,
  output logic    bit_we_o,
  output logic    carry_o,
  output logic    carry_we_o,
  output logic    cond_o
);
  always_comb begin
    bit_o      = bit_i;
    bit_we_o   = 1'b0;
    carry_o    = carry_i;
    carry_we_o = 1'b0;
    cond_o     = 1'b0;
    case (op_i)
      OP_ANL:   begin carry_o = carry_i &  bit_i; carry_we_o = 1'b1; end
      OP_ANL_N: begin carry_o = carry_i & ~bit_i; carry_we_o = 1'b1; end
      OP_ORL:   begin carry_o = carry_i |  bit_i; carry_we_o = 1'b1; end
      OP_ORL_N: begin carry_o = carry_i | ~bit_i; carry_we_o = 1'b1; end
      OP_MOV_C: begin carry_o = bit_i;            carry_we_o = 1'b1; end
      OP_MOV_B: begin bit_o = carry_i;  bit_we_o = 1'b1; end
      OP_CLR_C: begin carry_o = 1'b0;   carry_we_o = 1'b1; end
      OP_SET_C: begin carry_o = 1'b1;   carry_we_o = 1'b1; end
      OP_CPL_C: begin carry_o = ~carry_i; carry_we_o = 1'b1; end
      OP_CLR_B: begin bit_o = 1'b0;     bit_we_o = 1'b1; end
      OP_SET_B: begin bit_o = 1'b1;     bit_we_o = 1'b1; end
      OP_CPL_B: begin bit_o = ~bit_i;   bit_we_o = 1'b1; end
      OP_JBC:   begin cond_o = bit_i; bit_o = 1'b0; bit_we_o = bit_i; end
      OP_JB:    cond_o = bit_i;
      OP_JNB:   cond_o = ~bit_i;
      default:  ;
    endcase
  end
endmodule

// File: rtl/bitop_merge.sv
module bitop_merge #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0]         byte_i,
  input  logic [$clog2(DATA_W)-1:0] idx_i,
  input  logic                      bit_i,
  output logic [DATA_W-1:0]         byte_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign byte_o[g] = (idx_i == g) ? bit_i : byte_i[g];
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 8,
  parameter int unsigned       DATA_W      = 8,
  parameter logic [ADDR_W-1:0] RAM_BASE    = 8'h20,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hD0,
  parameter int unsigned       CARRY_BIT   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [3:0]        op_i,
  input  logic [ADDR_W-1:0] bit_addr_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              carry_o,
  output logic              cond_o,
  output logic              done_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  // stage A
  logic              s1_vld;
  bit_op_e           s1_op;
  logic [ADDR_W-1:0] s1_byte;
  logic [IDX_W-1:0]  s1_idx;
  // stage B
  logic              s2_vld;
  bit_op_e           s2_op;
  logic [ADDR_W-1:0] s2_byte;
  logic [IDX_W-1:0]  s2_idx;
  logic [DATA_W-1:0] s2_rdata;

  logic              carry_q;
  logic [ADDR_W-1:0] dec_byte;
  logic [IDX_W-1:0]  dec_idx;

  logic              alu_bit, alu_bit_we, alu_carry, alu_carry_we, alu_cond;
  logic              wr_en, carry_we, carry_new, carry_fwd;
  logic [DATA_W-1:0] wdata, rd_raw, rd_eff;

  bitop_addr_dec #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RAM_BASE(RAM_BASE)
  ) u_dec (
    .bit_addr_i (bit_addr_i),
    .byte_addr_o(dec_byte),
    .bit_idx_o  (dec_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_op   <= OP_NOP;
      s1_byte <= '0;
      s1_idx  <= '0;
    end else begin
      s1_vld <= op_valid_i;
      if (op_valid_i) begin
        s1_op   <= bit_op_e'(op_i);
        s1_byte <= dec_byte;
        s1_idx  <= dec_idx;
      end
    end
  end

  assign mem_rd_o    = s1_vld && op_uses_mem(s1_op);
  assign mem_raddr_o = s1_byte;

  // forward stage B result into a same-byte read
  assign rd_raw    = (wr_en && (s2_byte == s1_byte)) ? wdata : mem_rdata_i;
  assign carry_fwd = carry_we ? carry_new : carry_q;

  always_comb begin
    rd_eff = rd_raw;
    if (s1_byte == STATUS_ADDR) rd_eff[CARRY_BIT] = carry_fwd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld   <= 1'b0;
      s2_op    <= OP_NOP;
      s2_byte  <= '0;
      s2_idx   <= '0;
      s2_rdata <= '0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_op    <= s1_op;
        s2_byte  <= s1_byte;
        s2_idx   <= s1_idx;
        s2_rdata <= rd_eff;
      end
    end
  end

  bitop_alu u_alu (
    .op_i      (s2_op),
    .bit_i     (s2_rdata[s2_idx]),
    .carry_i   (carry_q),
    .bit_o     (alu_bit),
    .bit_we_o  (alu_bit_we),
    .carry_o   (alu_carry),
    .carry_we_o(alu_carry_we),
    .cond_o    (alu_cond)
  );

  bitop_merge #(.DATA_W(DATA_W)) u_merge (
    .byte_i(s2_rdata),
    .idx_i (s2_idx),
    .bit_i (alu_bit),
    .byte_o(wdata)
  );

  assign wr_en     = s2_vld && alu_bit_we;
  assign carry_we  = s2_vld && (alu_carry_we ||
                     (alu_bit_we && (s2_byte == STATUS_ADDR) && (s2_idx == IDX_W'(CARRY_BIT))));
  assign carry_new = alu_carry_we ? alu_carry : alu_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       carry_q <= 1'b0;
    else if (carry_we) carry_q <= carry_new;
  end

  assign mem_wr_o    = wr_en;
  assign mem_waddr_o = s2_byte;
  assign mem_wdata_o = wdata;
  assign carry_o     = carry_q;
  assign cond_o      = s2_vld && alu_cond;
  assign done_o      = s2_vld;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int unsigned       ADDR_W      = 8,
  parameter int unsigned       DATA_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hD0,
  parameter int unsigned       CARRY_BIT   = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] mem_raddr_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_waddr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] s2_rdata,
  input logic              carry_o,
  input logic              done_o
);
  // R3
  a_r3_single_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ($countones(mem_wdata_o ^ s2_rdata) <= 1));

  // R12
  a_r12_wr_follows_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ($past(mem_rd_o) && (mem_waddr_o == $past(mem_raddr_o))));

  // R1 and R2
  a_r2_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> ((mem_raddr_o >= 8'h20 && mem_raddr_o <= 8'h2F) ||
                  (mem_raddr_o[ADDR_W-1] && mem_raddr_o[2:0] == 3'b000)));

  // R10
  a_r10_status_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && mem_waddr_o == STATUS_ADDR &&
     mem_wdata_o[CARRY_BIT] != s2_rdata[CARRY_BIT])
    |=> (carry_o == $past(mem_wdata_o[CARRY_BIT])));

  // R12
  a_r12_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(op_valid_i, 2));
endmodule

bind bitop_unit bitop_unit_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .STATUS_ADDR(STATUS_ADDR),
  .CARRY_BIT  (CARRY_BIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .mem_rd_o   (mem_rd_o),
  .mem_raddr_o(mem_raddr_o),
  .mem_wr_o   (mem_wr_o),
  .mem_waddr_o(mem_waddr_o),
  .mem_wdata_o(mem_wdata_o),
  .s2_rdata   (s2_rdata),
  .carry_o    (carry_o),
  .done_o     (done_o)
);

// File: tb/tb_bitop_unit.sv
`timescale 1ns/1ps
module tb_bitop_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] baddr = 8'd0;
  logic       mem_rd, mem_wr, carry, cond, done;
  logic [7:0] raddr, waddr, wdata, rdata;

  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];
  logic       ref_c;
  int         checks = 0;
  int         failures = 0;
  int         wr_cnt = 0;
  int         cycles = 0;

  always #4 clk = ~clk;

  bitop_unit dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .op_valid_i (op_valid),
    .op_i       (op),
    .bit_addr_i (baddr),
    .mem_rd_o   (mem_rd),
    .mem_raddr_o(raddr),
    .mem_rdata_i(rdata),
    .mem_wr_o   (mem_wr),
    .mem_waddr_o(waddr),
    .mem_wdata_o(wdata),
    .carry_o    (carry),
    .cond_o     (cond),
    .done_o     (done)
  );

  assign rdata = mem[raddr];

  always @(posedge clk) begin
    if (mem_wr) begin
      mem[waddr] <= wdata;
      wr_cnt     <= wr_cnt + 1;
    end
  end

  task automatic report;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: R12 run did not end, actual=%0d expected<=150000", cycles);
      report();
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd1, 4'd2, 4'd3, 4'd4:  return "R4";
      4'd5, 4'd6:              return "R5";
      4'd7, 4'd8, 4'd9:        return "R6";
      4'd10, 4'd11, 4'd12:     return "R7";
      4'd13:                   return "R8";
      default:                 return "R9";
    endcase
  endfunction

  function automatic logic [7:0] byte_of(input logic [7:0] a);
    return a[7] ? {a[7:3], 3'b000} : 8'h20 + {4'h0, a[6:3]};
  endfunction

  function automatic logic uses_mem(input logic [3:0] o);
    return !(o == 4'd0 || o == 4'd7 || o == 4'd8 || o == 4'd9);
  endfunction

  // Arithmetic reference for one operation.
  task automatic ref_step(input logic [3:0] o, input logic [7:0] a, output logic c_out, output logic w_out);
    logic [7:0] by;
    logic [7:0] rb;
    logic [2:0] ix;
    logic       b, nb, wr;
    by = byte_of(a);
    ix = a[2:0];
    rb = ref_mem[by];
    if (by == 8'hD0) rb[7] = ref_c;
    b  = rb[ix];
    nb = b;
    wr = 1'b0;
    c_out = 1'b0;
    case (o)
      4'd1:  ref_c = ref_c & b;
      4'd2:  ref_c = ref_c & ~b;
      4'd3:  ref_c = ref_c | b;
      4'd4:  ref_c = ref_c | ~b;
      4'd5:  ref_c = b;
      4'd6:  begin nb = ref_c; wr = 1'b1; end
      4'd7:  ref_c = 1'b0;
      4'd8:  ref_c = 1'b1;
      4'd9:  ref_c = ~ref_c;
      4'd10: begin nb = 1'b0;  wr = 1'b1; end
      4'd11: begin nb = 1'b1;  wr = 1'b1; end
      4'd12: begin nb = ~b;    wr = 1'b1; end
      4'd13: begin c_out = b; nb = 1'b0; wr = b; end
      4'd14: c_out = b;
      4'd15: c_out = ~b;
      default: ;
    endcase
    if (wr) begin
      rb[ix] = nb;
      ref_mem[by] = rb;
      if (by == 8'hD0 && ix == 3'd7) ref_c = nb;
    end
    w_out = wr;
  endtask

  task automatic do_op(input logic [3:0] o, input logic [7:0] a);
    logic ec, ew;
    int   w0;
    string tag;
    tag = req_of(o);
    ref_step(o, a, ec, ew);
    w0 = wr_cnt;
    @(negedge clk);
    op_valid = 1'b1; op = o; baddr = a;
    @(negedge clk);
    op_valid = 1'b0;
    chk(uses_mem(o) ? "R12" : "R6", {7'd0, mem_rd}, {7'd0, uses_mem(o)}, "read strobe");
    if (uses_mem(o)) chk(a[7] ? "R2" : "R1", raddr, byte_of(a), "read byte address");
    @(negedge clk);
    chk("R12", {7'd0, done}, 8'd1, "done");
    chk(tag, {7'd0, cond}, {7'd0, ec}, "cond");
    @(negedge clk);
    chk(tag, {7'd0, carry}, {7'd0, ref_c}, "carry");
    chk(tag, 8'(wr_cnt - w0), {7'd0, ew}, "write count");
    chk("R3", mem[byte_of(a)], ref_mem[byte_of(a)], "target byte");
  endtask

  // R11: back-to-back issue
  task automatic do_pair(input logic [3:0] o1, input logic [7:0] a1,
                         input logic [3:0] o2, input logic [7:0] a2);
    logic c1, c2, w1, w2;
    ref_step(o1, a1, c1, w1);
    ref_step(o2, a2, c2, w2);
    @(negedge clk);
    op_valid = 1'b1; op = o1; baddr = a1;
    @(negedge clk);
    op = o2; baddr = a2;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R11", {7'd0, cond}, {7'd0, c1}, "first cond");
    @(negedge clk);
    chk("R11", {7'd0, cond}, {7'd0, c2}, "second cond");
    @(negedge clk);
    chk("R11", {7'd0, carry}, {7'd0, ref_c}, "carry");
    chk("R11", mem[byte_of(a1)], ref_mem[byte_of(a1)], "first byte");
    chk("R11", mem[byte_of(a2)], ref_mem[byte_of(a2)], "second byte");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 73 + 29);
      ref_mem[i] = 8'(i * 73 + 29);
    end
    ref_c = 1'b0;
    repeat (3) @(negedge clk);
    // R13
    chk("R13", {7'd0, carry}, 8'd0, "carry in reset");
    chk("R13", {6'd0, mem_rd, mem_wr}, 8'd0, "strobes in reset");
    chk("R13", {6'd0, done, cond}, 8'd0, "done/cond in reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int o = 1; o < 16; o++)
      for (int a = 0; a < 256; a++)
        do_op(4'(o), 8'(a));

    // R10: status bit 7 aliases the carry
    do_op(4'd11, 8'hD7);
    chk("R10", {7'd0, carry}, 8'd1, "carry after setting status bit 7");
    do_op(4'd10, 8'hD7);
    chk("R10", {7'd0, carry}, 8'd0, "carry after clearing status bit 7");
    do_op(4'd8, 8'h00);
    do_op(4'd14, 8'hD7);
    chk("R10", {7'd0, ref_c}, 8'd1, "model carry set");
    do_op(4'd12, 8'hD2);
    chk("R10", mem[8'hD0] & 8'h80, 8'h80, "status byte bit 7 carries C on writeback");

    do_pair(4'd11, 8'h00, 4'd12, 8'h01);
    do_pair(4'd11, 8'h10, 4'd12, 8'h10);
    do_pair(4'd13, 8'h10, 4'd14, 8'h10);
    do_pair(4'd9,  8'h00, 4'd6,  8'hD3);
    do_pair(4'd11, 8'hD7, 4'd5,  8'hD7);
    do_pair(4'd10, 8'hD7, 4'd4,  8'h8F);
    do_pair(4'd12, 8'h7F, 4'd12, 8'h78);
    do_pair(4'd7,  8'h00, 4'd3,  8'hF1);

    report();
  end
endmodule